// File: doc/BRIEF.md
# 64-bit Timestamp Counter with Snapshot and Preload

This block keeps a free-running 64-bit up-count that serves as the system time base. It sits behind a plain 32-bit register port: one write strobe, one read strobe, a byte address and a data word. A 16-bit prescaler in the control word sets how many bus clock cycles pass between two increments.

A 32-bit bus cannot read a 64-bit value in one access. Software therefore first writes a snapshot command to the control word. That command copies the whole count into two capture words in a single cycle. Software then reads the upper and lower capture words at its leisure, and they hold until the next snapshot.

To set the time, software fills two staging words and then writes a preload command to the control word. The count takes the staged value and keeps running from there, and the prescaler phase starts over at the same moment.

Top module: `tsc_timer`

## Requirements
- R1: After reset, the count, the prescaler field, the staging words and the capture words are all zero. The count then starts advancing at once.
- R2: The count advances by one each time the prescaler phase reaches the prescaler value P (control bits [31:16]). The phase then returns to zero. With a fixed P, this gives one step every P+1 clock cycles. If P is lowered below the current phase, the next cycle counts as reaching it.
- R3: A control write (byte offset 0x68) with bit 0 set and bit 1 clear copies the count as it stood at that clock edge into both capture words (upper at 0x80, lower at 0x7C) in the same cycle.
- R4: The capture words change only on a snapshot command. Counting, preloads and writes elsewhere leave them unchanged.
- R5: A control write with bits 0 and 1 both set loads the count from the staging words (lower at 0x74, upper at 0x78). The loaded value is visible on the live words (lower at 0x6C, upper at 0x70) right after that edge.
- R6: A preload restarts the prescaler phase. With prescaler P, the first increment after the load lands P+1 cycles after it.
- R7: Reading the control word returns the prescaler field in bits [31:16] as last written. Bits [15:0] read as zero, so both command bits read back as zero.
- R8: The count wraps from all ones to zero and continues, with no flag of any kind.
- R9: Writes to the live words and to the capture words have no effect.
- R10: The staging words read back as written. A control write with bit 0 clear only updates the prescaler and issues no command.
- R11: Read data is zero whenever the read strobe is low, and zero for any unmapped address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; also the counting clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, acts at the clock edge |
| rdEn | input | 1 | Read strobe; read data follows the address in the same cycle |
| addr | input | 8 | Byte address of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, zero when rdEn is low |

## Verification
The bench targets the preload edge and the carry across the word boundary.

A load of all ones minus one must roll into the upper word and then to zero. A design that drops the carry, or that flags the wrap, shows the wrong upper word. A design that leaves the phase running across a preload steps too early after the load. A design that captures the count one edge late returns a snapshot that is off by one.

Random traffic mixes prescaler changes (including a cut below the running phase), writes to read-only words, unmapped reads and idle read strobes. Any decode that leaks a write, or that echoes a command bit, shows up as a wrong read value.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int BUS_W     = 32;
  localparam int CNT_W     = 2 * BUS_W;
  localparam int HALVES    = CNT_W / BUS_W;
  localparam int PRESC_W   = 16;
  localparam int PRESC_LSB = BUS_W - PRESC_W;
  localparam int ADDR_W    = 8;

  localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h68;
  localparam logic [ADDR_W-1:0] OFF_LIVELO = 8'h6C;
  localparam logic [ADDR_W-1:0] OFF_LIVEHI = 8'h70;
  localparam logic [ADDR_W-1:0] OFF_STGLO  = 8'h74;
  localparam logic [ADDR_W-1:0] OFF_STGHI  = 8'h78;
  localparam logic [ADDR_W-1:0] OFF_CAPLO  = 8'h7C;
  localparam logic [ADDR_W-1:0] OFF_CAPHI  = 8'h80;

  // command bits inside the control word
  localparam int CMD_GO_BIT   = 0;
  localparam int CMD_LOAD_BIT = 1;

  typedef struct packed {
    logic               snapStb;
    logic               loadStb;
    logic [CNT_W-1:0]   loadVal;
    logic [PRESC_W-1:0] prescVal;
  } tsStrobes_t;
endpackage

// File: rtl/tsc_prescaler.sv
module tsc_prescaler
  import tsc_pkg::*;
#(
  parameter int DIV_W = PRESC_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             restart,
  input  logic [DIV_W-1:0] divVal,
  output logic             tick
);
  logic [DIV_W-1:0] phase;

  // reaching or passing the limit both end the period
  assign tick = (phase >= divVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= '0;
    end else if (restart || tick) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/tsc_datapath.sv
module tsc_datapath
  import tsc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  tsStrobes_t       stb,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] latVal
);
  logic tick;

  tsc_prescaler #(.DIV_W(PRESC_W)) u_presc (
    .clk     (clk),
    .rstN    (rstN),
    .restart (stb.loadStb),
    .divVal  (stb.prescVal),
    .tick    (tick)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal <= '0;
    end else if (stb.loadStb) begin
      cntVal <= stb.loadVal;
    end else if (tick) begin
      cntVal <= cntVal + 1'b1;
    end
  end

  // capture words, one register per bus-width slice
  for (genvar h = 0; h < HALVES; h++) begin : g_cap
    logic [BUS_W-1:0] capHalf;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        capHalf <= '0;
      end else if (stb.snapStb) begin
        capHalf <= cntVal[h*BUS_W +: BUS_W];
      end
    end
    assign latVal[h*BUS_W +: BUS_W] = capHalf;
  end
endmodule

// File: rtl/tsc_ctrl.sv
module tsc_ctrl
  import tsc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wrData,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic [CNT_W-1:0]  latVal,
  output tsStrobes_t        stb,
  output logic [BUS_W-1:0]  rdData
);
  logic [PRESC_W-1:0] prescReg;
  logic [CNT_W-1:0]   stageVal;
  logic               ctrlHit;

  assign ctrlHit = wrEn && (addr == OFF_CTRL);

  localparam logic [ADDR_W-1:0] STG_OFF [HALVES] = '{OFF_STGLO, OFF_STGHI};

  for (genvar h = 0; h < HALVES; h++) begin : g_stage
    logic [BUS_W-1:0] stgHalf;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stgHalf <= '0;
      end else if (wrEn && (addr == STG_OFF[h])) begin
        stgHalf <= wrData;
      end
    end
    assign stageVal[h*BUS_W +: BUS_W] = stgHalf;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prescReg <= '0;
    end else if (ctrlHit) begin
      prescReg <= wrData[PRESC_LSB +: PRESC_W];
    end
  end

  always_comb begin
    stb.snapStb  = ctrlHit && wrData[CMD_GO_BIT] && !wrData[CMD_LOAD_BIT];
    stb.loadStb  = ctrlHit && wrData[CMD_GO_BIT] && wrData[CMD_LOAD_BIT];
    stb.loadVal  = stageVal;
    stb.prescVal = prescReg;
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      unique case (addr)
        OFF_CTRL:   rdData = {prescReg, {PRESC_LSB{1'b0}}};
        OFF_LIVELO: rdData = cntVal[0 +: BUS_W];
        OFF_LIVEHI: rdData = cntVal[BUS_W +: BUS_W];
        OFF_STGLO:  rdData = stageVal[0 +: BUS_W];
        OFF_STGHI:  rdData = stageVal[BUS_W +: BUS_W];
        OFF_CAPLO:  rdData = latVal[0 +: BUS_W];
        OFF_CAPHI:  rdData = latVal[BUS_W +: BUS_W];
        default:    rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/tsc_timer.sv
module tsc_timer
  import tsc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wrData,
  output logic [BUS_W-1:0]  rdData
);
  tsStrobes_t       strobes;
  logic [CNT_W-1:0] cntVal;
  logic [CNT_W-1:0] latVal;

  tsc_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .wrData (wrData),
    .cntVal (cntVal),
    .latVal (latVal),
    .stb    (strobes),
    .rdData (rdData)
  );

  tsc_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (strobes),
    .cntVal (cntVal),
    .latVal (latVal)
  );
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker
  import tsc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [BUS_W-1:0]  wrData,
  input logic [BUS_W-1:0]  rdData,
  input logic [CNT_W-1:0]  cntVal,
  input logic [CNT_W-1:0]  latVal,
  input tsStrobes_t        stb
);
  logic snapCmd, loadCmd;
  assign snapCmd = wrEn && addr == OFF_CTRL && wrData[1:0] == 2'b01;
  assign loadCmd = wrEn && addr == OFF_CTRL && wrData[1:0] == 2'b11;

  // R3
  snap_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    snapCmd |=> latVal == $past(cntVal));

  // R4
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !snapCmd |=> $stable(latVal));

  // R5
  load_apply_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadCmd |=> cntVal == $past(stb.loadVal));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadCmd |=> (cntVal == $past(cntVal)) || (cntVal == $past(cntVal) + 1'b1));

  // R8
  wrap_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadCmd |=> (cntVal != '0) || ($past(cntVal) == '0) || ($past(cntVal) == '1));

  // R7
  ctrl_low_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == OFF_CTRL) |-> rdData[PRESC_LSB-1:0] == '0);

  // R11
  idle_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> rdData == '0);
endmodule

bind tsc_timer tsc_checker u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .rdEn   (rdEn),
  .addr   (addr),
  .wrData (wrData),
  .rdData (rdData),
  .cntVal (cntVal),
  .latVal (latVal),
  .stb    (strobes)
);

// File: tb/tb_tsc_timer.sv
module tb_tsc_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;

  int total = 0;
  int bad = 0;

  localparam logic [7:0] A_CTRL = 8'h68, A_LLO = 8'h6C, A_LHI = 8'h70,
                         A_SLO = 8'h74, A_SHI = 8'h78, A_CLO = 8'h7C, A_CHI = 8'h80;

  tsc_timer dut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
                 .addr(addr), .wrData(wrData), .rdData(rdData));

  always #10 clk = ~clk;

  // behavioural model of the requirements
  logic [63:0] mCnt, mStg, mCap;
  logic [15:0] mPre, mPh;

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = '0; mStg = '0; mCap = '0; mPre = '0; mPh = '0;
    end else begin
      logic isCtrl, doSnap, doLoad, hit;
      isCtrl = wrEn && addr == A_CTRL;
      doSnap = isCtrl && wrData[1:0] == 2'b01;
      doLoad = isCtrl && wrData[1:0] == 2'b11;
      hit = (mPh >= mPre);
      if (doSnap) mCap = mCnt;
      if (doLoad) begin
        mCnt = mStg; mPh = '0;
      end else if (hit) begin
        mCnt = mCnt + 64'd1; mPh = '0;
      end else begin
        mPh = mPh + 16'd1;
      end
      if (isCtrl) mPre = wrData[31:16];
      if (wrEn && addr == A_SLO) mStg[31:0] = wrData;
      if (wrEn && addr == A_SHI) mStg[63:32] = wrData;
    end
  end

  function automatic logic [31:0] expRead(input logic [7:0] a);
    case (a)
      A_CTRL: return {mPre, 16'h0};
      A_LLO:  return mCnt[31:0];
      A_LHI:  return mCnt[63:32];
      A_SLO:  return mStg[31:0];
      A_SHI:  return mStg[63:32];
      A_CLO:  return mCap[31:0];
      A_CHI:  return mCap[63:32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, output logic [31:0] got);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #2;
    got = rdData;
    chk(req, got, expRead(a));
    rdEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, hiA, loA;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd("R1", A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    rd("R1", A_SLO, v);  chk("R1 stage", v, 32'h0);
    rd("R1", A_CHI, v);  chk("R1 capture", v, 32'h0);
    rd("R1", A_LHI, v);  chk("R1 live hi", v, 32'h0);

    // R11 idle strobe returns zero
    @(negedge clk); addr = A_LLO; rdEn = 1'b0; #2;
    chk("R11 idle", rdData, 32'h0);
    rd("R11 unmapped", 8'h04, v); chk("R11 unmapped", v, 32'h0);

    // R6/R2 preload zero with prescaler 2: steps at 3,6,..
    wr(A_SLO, 32'h0); wr(A_SHI, 32'h0);
    wr(A_CTRL, 32'h0002_0003);
    rd("R6", A_LLO, v); chk("R6 k1", v, 32'd0);
    rd("R6", A_LLO, v); chk("R6 k2", v, 32'd0);
    rd("R6", A_LLO, v); chk("R6 k3", v, 32'd1);
    rd("R2", A_LLO, v); rd("R2", A_LLO, v); rd("R2", A_LLO, v);
    chk("R2 k6", v, 32'd2);
    // R7 command bits read as zero
    rd("R7", A_CTRL, v); chk("R7 ctrl", v, 32'h0002_0000);

    // R8 wrap across 64 bits
    wr(A_SLO, 32'hFFFF_FFFE); wr(A_SHI, 32'hFFFF_FFFF);
    rd("R10", A_SHI, v); chk("R10 stage hi", v, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'h0000_0003);
    rd("R8", A_LHI, v); chk("R8 before", v, 32'hFFFF_FFFF);
    rd("R8", A_LLO, v); chk("R8 lo zero", v, 32'h0);
    rd("R8", A_LHI, v); chk("R8 hi zero", v, 32'h0);

    // R5 preload visible, R3 snapshot
    wr(A_SLO, 32'h1234_5678); wr(A_SHI, 32'h0000_00AB);
    wr(A_CTRL, 32'h0004_0003);
    rd("R5", A_LHI, v); chk("R5 hi", v, 32'h0000_00AB);
    wr(A_CTRL, 32'h0004_0001);
    rd("R3", A_CHI, hiA); rd("R3", A_CLO, loA);
    chk("R3 hi", hiA, 32'h0000_00AB);
    // R4 capture holds across preload and counting
    wr(A_SLO, 32'h0); wr(A_CTRL, 32'h0004_0003);
    repeat (10) @(negedge clk);
    rd("R4", A_CLO, v); chk("R4 lo", v, loA);
    // R10 bit0 clear: no command
    wr(A_CTRL, 32'h0001_0002);
    rd("R10", A_CHI, v); chk("R10 nocmd", v, hiA);
    // R9 read-only words
    wr(A_LLO, 32'hDEAD_BEEF); rd("R9", A_LLO, v);
    wr(A_CLO, 32'hCAFE_F00D); rd("R9", A_CLO, v); chk("R9 cap", v, loA);

    // random traffic
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0: wr(A_CTRL, {16'($urandom_range(0, 5)), 14'h0, 2'($urandom_range(0, 3))});
        1: wr($urandom_range(0, 1) ? A_SLO : A_SHI, $urandom);
        2: begin
          logic [7:0] ra;
          ra = $urandom_range(0, 1) ? A_LLO : ($urandom_range(0, 1) ? A_CHI : A_LHI);
          wr(ra, $urandom);
        end
        3: begin
          logic [7:0] aa [8];
          aa = '{A_CTRL, A_LLO, A_LHI, A_SLO, A_SHI, A_CLO, A_CHI, 8'h84};
          rd("R2/R4/R9/R11 rand", aa[$urandom_range(0, 7)], v);
        end
        4: rd("R2 rand", A_LLO, v);
        default: repeat ($urandom_range(1, 4)) @(negedge clk);
      endcase
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule